// File: doc/BRIEF.md
# Scatter-Gather Sector DMA Engine

This block moves sector data between a disk-style device data port and system memory. Software builds a table of region descriptors in memory, loads the table's base address, and sets the go bit in the command register. The engine then reads descriptors one at a time and moves 16-bit words. In the device-to-memory direction, words offered by the device are written to memory. In the memory-to-device direction, words read from memory are handed to the device. Each descriptor is two little-endian 32-bit words. The first is the buffer address. The second is the byte count, and its bit 31 flags the final descriptor.

The final status tells software how the descriptor table compared with the device transfer. A table that matched the device exactly, one that was too long, one that was too short, and a transfer stopped by software each leave a different status. The interrupt line follows the interrupt status bit. A bus-master enable input keeps the engine off the memory port entirely.

Top module: `sg_ide_dma`

## Requirements
- R1: After reset the status register reads 0, `irq` is low, and no memory request, device ready or device valid is asserted.
- R2: Writing the command register at offset 0 with bit 0 set, while the stored go bit is clear, starts the engine. The engine then reads four halfwords at the table base (offset 4, bits 1:0 ignored), base+2, base+4 and base+6, in that order. Descriptor word 0 is the buffer address and word 1 is the byte count, each low half first.
- R3: With command bit 3 set at start, each device word (`dev_rx_valid` and `dev_rx_ready`) is written to memory at the buffer address, and the address then steps by 2.
- R4: With command bit 3 clear at start, each word read from memory at the buffer address is presented on `dev_tx_data` with `dev_tx_valid` in the same cycle as the memory acknowledge.
- R5: After a descriptor without bit 31 of its count word is used up, the engine reads the next descriptor, 8 bytes further on.
- R6: If the device signals `dev_done` after the table is used up, the status (offset 2) reads 0x4: interrupt bit 2 is set, active bit 0 is clear, and error bit 1 always reads 0.
- R7: If `dev_done` arrives while table bytes remain, the status reads 0x5.
- R8: If the table is used up and the device then asks for another word, the engine accepts no word, active clears, and the interrupt bit stays clear.
- R9: Writing 0 to bit 0 of the command register stops the engine at once and clears active. Any device word offered afterwards is not accepted. The interrupt bit is left as it was.
- R10: Writing 1 to status bit 2 clears the interrupt, and writing 0 there leaves it unchanged. `irq` always equals status bit 2.
- R11: If `bm_en` is low at start, the engine issues no memory request. It accepts device words (memory-to-device direction: supplies zero words) until `dev_done`, and then the status reads 0x5.
- R12: A byte count field of zero in bits 15:0 means 65536 bytes, which is 32768 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register write offset |
| reg_wdata | input | 32 | Register write data |
| reg_rd_addr | input | 3 | Register read offset |
| reg_rdata | output | 32 | Register read data |
| bm_en | input | 1 | Bus-master enable |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_ack | input | 1 | Memory request accepted this cycle |
| mem_rdata | input | 16 | Memory read data, valid with mem_ack |
| dev_rx_valid | input | 1 | Device offers a word |
| dev_rx_data | input | 16 | Device word |
| dev_rx_ready | output | 1 | Engine takes the device word |
| dev_tx_valid | output | 1 | Engine offers a word to the device |
| dev_tx_data | output | 16 | Word for the device |
| dev_tx_ready | input | 1 | Device wants a word |
| dev_done | input | 1 | Device has finished its transfer |
| irq | output | 1 | Interrupt |

## Verification
A wrong descriptor index or pointer shows up on `mem_addr` at the very next memory request, either as a read out of order or as data landing at the wrong place. A miscounted remaining length moves the switch from transfer to drain one word early or late. At the device port this appears as one word too many or too few accepted, and two cycles after `dev_done` the status then reads 0x5 where 0x4 was due, or the reverse. A wrong status or interrupt flag is visible on `irq` in the cycle after it goes wrong.

// File: rtl/bmd_pkg.sv
package bmd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_XFER  = 3'd2,
    ST_DRAIN = 3'd3,
    ST_HOLD  = 3'd4,
    ST_NOBM  = 3'd5
  } bmd_state_e;

  localparam logic [2:0] OFF_CMD  = 3'd0;
  localparam logic [2:0] OFF_STAT = 3'd2;
  localparam logic [2:0] OFF_BASE = 3'd4;

  localparam int CMD_GO    = 0;
  localparam int CMD_TOMEM = 3;
  localparam int STS_ACT   = 0;
  localparam int STS_INT   = 2;
endpackage

// File: rtl/bmd_ctrl.sv
module bmd_ctrl
  import bmd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              bm_en,
  input  logic              dev_done,
  input  logic              fetch_done,
  input  logic              word_move,
  input  logic              last_word,
  input  logic              desc_eot,
  input  logic              dev_more,
  output bmd_state_e        state,
  output logic              dir_tomem,
  output logic              intr,
  output logic              go,
  output logic [ADDR_W-1:0] tbl_base,
  output logic              start_pulse
);
  bmd_state_e        state_q, state_d;
  logic              go_q, dir_q, intr_q, intr_d;
  logic [ADDR_W-1:0] base_q;
  logic              cmd_wr, stat_wr, base_wr, stop_pulse, set_int, clr_int;

  assign cmd_wr      = reg_wr && (reg_addr == OFF_CMD);
  assign stat_wr     = reg_wr && (reg_addr == OFF_STAT);
  assign base_wr     = reg_wr && (reg_addr == OFF_BASE);
  assign start_pulse = cmd_wr && reg_wdata[CMD_GO] && !go_q;
  assign stop_pulse  = cmd_wr && !reg_wdata[CMD_GO];

  always_comb begin
    state_d = state_q;
    if (stop_pulse) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE:  if (start_pulse) state_d = bm_en ? ST_FETCH : ST_NOBM;
        ST_FETCH: begin
          if (dev_done)        state_d = ST_HOLD;
          else if (fetch_done) state_d = ST_XFER;
        end
        ST_XFER: begin
          if (dev_done)                    state_d = ST_HOLD;
          else if (word_move && last_word) state_d = desc_eot ? ST_DRAIN : ST_FETCH;
        end
        ST_DRAIN: if (dev_done || dev_more) state_d = ST_IDLE;
        ST_NOBM:  if (dev_done) state_d = ST_HOLD;
        default:  state_d = state_q;
      endcase
    end
  end

  assign set_int = dev_done && !stop_pulse &&
                   (state_q == ST_FETCH || state_q == ST_XFER ||
                    state_q == ST_NOBM  || state_q == ST_DRAIN);
  assign clr_int = stat_wr && reg_wdata[STS_INT];

  always_comb begin
    intr_d = intr_q;
    if (set_int)      intr_d = 1'b1;
    else if (clr_int) intr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      go_q    <= 1'b0;
      dir_q   <= 1'b0;
      intr_q  <= 1'b0;
      base_q  <= '0;
    end else begin
      state_q <= state_d;
      intr_q  <= intr_d;
      if (cmd_wr)      go_q   <= reg_wdata[CMD_GO];
      if (start_pulse) dir_q  <= reg_wdata[CMD_TOMEM];
      if (base_wr)     base_q <= reg_wdata[ADDR_W-1:0];
    end
  end

  assign state     = state_q;
  assign dir_tomem = dir_q;
  assign intr      = intr_q;
  assign go        = go_q;
  assign tbl_base  = base_q;

  p_exact_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DRAIN && dev_done && !stop_pulse) |=> (state_q == ST_IDLE && intr_q));

  p_long_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_FETCH || state_q == ST_XFER) && dev_done && !stop_pulse)
      |=> (state_q == ST_HOLD && intr_q));

  p_short_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DRAIN && dev_more && !dev_done && !stop_pulse && !stat_wr)
      |=> (state_q == ST_IDLE && $stable(intr_q)));

  p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |=> (state_q == ST_IDLE));

  p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_int && !dev_done) |=> !intr_q);
endmodule

// File: rtl/bmd_desc.sv
module bmd_desc #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic              fetch_ack,
  input  logic [15:0]       mem_rdata,
  input  logic              word_move,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              fetch_done,
  output logic              last_word,
  output logic              desc_eot
);
  localparam int LEN_W = 16;
  localparam int REM_W = LEN_W;

  logic [ADDR_W-1:2] ptr_q, ptr_d;
  logic [1:0]        idx_q, idx_d;
  logic [ADDR_W-1:1] cur_q, cur_d;
  logic [REM_W-1:0]  rem_q, rem_d;
  logic              eot_q, eot_d;
  logic [LEN_W:0]    len_bytes;

  assign len_bytes = (mem_rdata == '0) ? (LEN_W+1)'(1) << LEN_W : {1'b0, mem_rdata};

  always_comb begin
    ptr_d = ptr_q;
    idx_d = idx_q;
    cur_d = cur_q;
    rem_d = rem_q;
    eot_d = eot_q;
    if (load) begin
      ptr_d = tbl_base[ADDR_W-1:2];
      idx_d = 2'd0;
    end else if (fetch_ack) begin
      idx_d = idx_q + 2'd1;
      case (idx_q)
        2'd0: cur_d[15:1]       = mem_rdata[15:1];
        2'd1: cur_d[ADDR_W-1:16] = mem_rdata[ADDR_W-17:0];
        2'd2: rem_d = REM_W'((len_bytes + 1'b1) >> 1);
        default: begin
          eot_d = mem_rdata[15];
          ptr_d = ptr_q + 2'd2;
        end
      endcase
    end else if (word_move) begin
      cur_d = cur_q + 1'b1;
      rem_d = rem_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      idx_q <= '0;
      cur_q <= '0;
      rem_q <= '0;
      eot_q <= 1'b0;
    end else begin
      ptr_q <= ptr_d;
      idx_q <= idx_d;
      cur_q <= cur_d;
      rem_q <= rem_d;
      eot_q <= eot_d;
    end
  end

  assign fetch_addr = {ptr_q, 2'b00} + ADDR_W'({idx_q, 1'b0});
  assign cur_addr   = {cur_q, 1'b0};
  assign fetch_done = fetch_ack && (idx_q == 2'd3);
  assign last_word  = (rem_q == REM_W'(1));
  assign desc_eot   = eot_q;

  p_fetch_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_ack && !load) |=> (idx_q == $past(idx_q) + 2'd1));

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (word_move && !load && !fetch_ack) |=> (cur_q == $past(cur_q) + 1'b1));
endmodule

// File: rtl/bmd_xfer.sv
module bmd_xfer
  import bmd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  bmd_state_e        state,
  input  logic              dir_tomem,
  input  logic              bm_en,
  input  logic              dev_done,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              mem_ack,
  input  logic [15:0]       mem_rdata,
  input  logic              rx_valid,
  input  logic [15:0]       rx_data,
  input  logic              tx_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [15:0]       tx_data,
  output logic              fetch_ack,
  output logic              word_move,
  output logic              dev_more
);
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_addr;
    mem_wdata = rx_data;
    rx_ready  = 1'b0;
    tx_valid  = 1'b0;
    tx_data   = mem_rdata;
    fetch_ack = 1'b0;
    word_move = 1'b0;
    dev_more  = 1'b0;
    case (state)
      ST_FETCH: begin
        mem_addr  = fetch_addr;
        mem_req   = bm_en && !dev_done;
        fetch_ack = mem_req && mem_ack;
      end
      ST_XFER: begin
        if (dir_tomem) begin
          mem_req  = bm_en && !dev_done && rx_valid;
          mem_we   = 1'b1;
          rx_ready = mem_req && mem_ack;
        end else begin
          mem_req  = bm_en && !dev_done && tx_ready;
          tx_valid = mem_req && mem_ack;
        end
        word_move = mem_req && mem_ack;
      end
      ST_DRAIN: dev_more = dir_tomem ? rx_valid : tx_ready;
      ST_NOBM: begin
        rx_ready = dir_tomem && !dev_done;
        tx_valid = !dir_tomem && !dev_done;
        tx_data  = '0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sg_ide_dma.sv
module sg_ide_dma
  import bmd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic [2:0]        reg_rd_addr,
  output logic [31:0]       reg_rdata,
  input  logic              bm_en,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [15:0]       mem_rdata,
  input  logic              dev_rx_valid,
  input  logic [15:0]       dev_rx_data,
  output logic              dev_rx_ready,
  output logic              dev_tx_valid,
  output logic [15:0]       dev_tx_data,
  input  logic              dev_tx_ready,
  input  logic              dev_done,
  output logic              irq
);
  logic              rst_meta, rst_s;
  bmd_state_e        state;
  logic              dir_tomem, intr, go, start_pulse;
  logic [ADDR_W-1:0] tbl_base, fetch_addr, cur_addr;
  logic              fetch_ack, fetch_done, word_move, last_word, desc_eot, dev_more;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  bmd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_s), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .bm_en(bm_en), .dev_done(dev_done),
    .fetch_done(fetch_done), .word_move(word_move), .last_word(last_word),
    .desc_eot(desc_eot), .dev_more(dev_more), .state(state),
    .dir_tomem(dir_tomem), .intr(intr), .go(go), .tbl_base(tbl_base),
    .start_pulse(start_pulse)
  );

  bmd_desc #(.ADDR_W(ADDR_W)) u_desc (
    .clk(clk), .rst_n(rst_s), .load(start_pulse), .tbl_base(tbl_base),
    .fetch_ack(fetch_ack), .mem_rdata(mem_rdata), .word_move(word_move),
    .fetch_addr(fetch_addr), .cur_addr(cur_addr), .fetch_done(fetch_done),
    .last_word(last_word), .desc_eot(desc_eot)
  );

  bmd_xfer #(.ADDR_W(ADDR_W)) u_xfer (
    .state(state), .dir_tomem(dir_tomem), .bm_en(bm_en), .dev_done(dev_done),
    .fetch_addr(fetch_addr), .cur_addr(cur_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .rx_valid(dev_rx_valid), .rx_data(dev_rx_data),
    .tx_ready(dev_tx_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rx_ready(dev_rx_ready),
    .tx_valid(dev_tx_valid), .tx_data(dev_tx_data), .fetch_ack(fetch_ack),
    .word_move(word_move), .dev_more(dev_more)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_rd_addr)
      OFF_CMD: begin
        reg_rdata[CMD_GO]    = go;
        reg_rdata[CMD_TOMEM] = dir_tomem;
      end
      OFF_STAT: begin
        reg_rdata[STS_ACT] = (state != ST_IDLE);
        reg_rdata[STS_INT] = intr;
      end
      OFF_BASE: reg_rdata[ADDR_W-1:0] = tbl_base;
      default:  reg_rdata = '0;
    endcase
  end

  assign irq = intr;

  p_quiet_nobm_r11: assert property (@(posedge clk) disable iff (!rst_s)
    (state == ST_NOBM) |-> !mem_req);

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(rst_s) |-> (!mem_req && !irq));
endmodule

// File: tb/sg_ide_dma_bench.sv
`timescale 1ns/1ps
module sg_ide_dma_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr, reg_rd_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        bm_en;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        dev_rx_valid, dev_rx_ready, dev_tx_valid, dev_tx_ready, dev_done;
  logic [15:0] dev_rx_data, dev_tx_data;
  logic        irq;

  logic [15:0] mem [0:255];
  logic [15:0] cap [0:15];
  int n_checks = 0;
  int n_fail = 0;
  int rd_cnt = 0;
  int req_cnt = 0;
  logic [31:0] first_rd, last_rd;
  bit done_flag = 0;

  always #4 clk = ~clk;

  sg_ide_dma u_sg_ide_dma (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rd_addr(reg_rd_addr), .reg_rdata(reg_rdata),
    .bm_en(bm_en), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .dev_rx_valid(dev_rx_valid), .dev_rx_data(dev_rx_data),
    .dev_rx_ready(dev_rx_ready), .dev_tx_valid(dev_tx_valid),
    .dev_tx_data(dev_tx_data), .dev_tx_ready(dev_tx_ready),
    .dev_done(dev_done), .irq(irq)
  );

  assign mem_rdata = mem[mem_addr[8:1]];

  always @(posedge clk) begin
    if (mem_req && mem_ack) begin
      req_cnt = req_cnt + 1;
      if (mem_we) mem[mem_addr[8:1]] <= mem_wdata;
      else begin
        if (rd_cnt == 0) first_rd = mem_addr;
        last_rd = mem_addr;
        rd_cnt = rd_cnt + 1;
      end
    end
  end

  // Vector fields: [25] to-memory, [24:17] table words, [16:9] device words,
  // [8] stop after device end, [7:0] expected status
  localparam int NV = 8;
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 8'd4, 8'd4, 1'b0, 8'h04},   // R3 R6 exact
    {1'b1, 8'd8, 8'd4, 1'b0, 8'h05},   // R7 long table
    {1'b1, 8'd2, 8'd4, 1'b0, 8'h00},   // R8 short table
    {1'b1, 8'd8, 8'd4, 1'b1, 8'h04},   // R9 stop after long
    {1'b0, 8'd4, 8'd4, 1'b0, 8'h04},   // R4 R6 exact
    {1'b0, 8'd8, 8'd3, 1'b0, 8'h05},   // R7 long table
    {1'b0, 8'd2, 8'd5, 1'b0, 8'h00},   // R8 short table
    {1'b1, 8'd1, 8'd1, 1'b0, 8'h04}    // R6 single word
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic read_reg(input logic [2:0] a, output logic [31:0] d);
    reg_rd_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic word_in(input logic [15:0] d, output bit ok);
    ok = 0;
    @(negedge clk);
    dev_rx_valid = 1'b1; dev_rx_data = d;
    for (int t = 0; t < 30 && !ok; t++) begin
      #1;
      if (dev_rx_ready) ok = 1;
      @(negedge clk);
    end
    dev_rx_valid = 1'b0;
  endtask

  task automatic word_out(output logic [15:0] d, output bit ok);
    ok = 0; d = '0;
    @(negedge clk);
    dev_tx_ready = 1'b1;
    for (int t = 0; t < 30 && !ok; t++) begin
      #1;
      if (dev_tx_valid) begin ok = 1; d = dev_tx_data; end
      @(negedge clk);
    end
    dev_tx_ready = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); dev_done = 1'b1;
    @(negedge clk); dev_done = 1'b0;
  endtask

  task automatic put_desc(input int slot, input logic [31:0] a, input logic [31:0] c);
    mem[slot]   = a[15:0];
    mem[slot+1] = a[31:16];
    mem[slot+2] = c[15:0];
    mem[slot+3] = c[31:16];
  endtask

  function automatic logic [15:0] pat(input int i, input int k);
    return {i[7:0], k[7:0]} ^ 16'hA500;
  endfunction

  task automatic run_vec(input int i);
    logic        tomem, stop;
    int          tw, dw, moved, exp_moved, bad;
    logic [7:0]  exp_st;
    logic [31:0] st;
    logic [15:0] w;
    bit          ok;
    string       tag;
    tomem = VEC[i][25]; tw = VEC[i][24:17]; dw = VEC[i][16:9];
    stop = VEC[i][8];   exp_st = VEC[i][7:0];
    reg_write(3'd0, 32'h0);
    reg_write(3'd2, 32'h4);
    put_desc(8'h80, 32'h40, 32'h8000_0000 | (tw * 2));
    for (int k = 0; k < 16; k++) mem[8'h20 + k] = tomem ? 16'h0 : pat(i, k);
    reg_write(3'd4, 32'h100);
    reg_write(3'd0, {28'h0, tomem, 3'b001});
    moved = 0;
    for (int k = 0; k < dw; k++) begin
      if (tomem) word_in(pat(i, k), ok);
      else begin word_out(w, ok); if (ok) cap[k] = w; end
      if (!ok) break;
      moved++;
    end
    if (moved == dw) pulse_done();
    if (stop) reg_write(3'd0, 32'h0);
    repeat (2) @(negedge clk);
    read_reg(3'd2, st);
    if (exp_st == 8'h00)   tag = "R8 status";
    else if (stop)         tag = "R9 status";
    else if (exp_st == 8'h05) tag = "R7 status";
    else                   tag = "R6 status";
    check(tag, st, {24'h0, exp_st});
    check("R10 irq", {31'h0, irq}, {31'h0, exp_st[2]});
    exp_moved = (tw < dw) ? tw : dw;
    check(tomem ? "R3 words moved" : "R4 words moved", moved, exp_moved);
    bad = 0;
    for (int k = 0; k < exp_moved; k++) begin
      if (tomem && mem[8'h20 + k] !== pat(i, k)) bad++;
      if (!tomem && cap[k] !== pat(i, k)) bad++;
    end
    check(tomem ? "R3 data" : "R4 data", bad, 0);
  endtask

  initial begin
    logic [31:0] st;
    logic [15:0] w;
    bit ok;
    int cnt, guard;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; reg_rd_addr = '0;
    bm_en = 1'b1; mem_ack = 1'b1; dev_rx_valid = 1'b0; dev_rx_data = '0;
    dev_tx_ready = 1'b0; dev_done = 1'b0;
    for (int k = 0; k < 256; k++) mem[k] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    read_reg(3'd2, st);
    check("R1 status in reset", st, 0);
    check("R1 outputs in reset", {28'h0, irq, mem_req, dev_rx_ready, dev_tx_valid}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    read_reg(3'd2, st);
    check("R1 status after reset", st, 0);
    check("R1 no request after reset", {31'h0, mem_req}, 0);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R2 R5: two chained descriptors
    reg_write(3'd0, 32'h0);
    reg_write(3'd2, 32'h4);
    put_desc(8'hC0, 32'h40, 32'h4);
    put_desc(8'hC4, 32'h60, 32'h8000_0004);
    reg_write(3'd4, 32'h183);
    rd_cnt = 0;
    reg_write(3'd0, 32'h9);
    for (int k = 0; k < 4; k++) word_in(16'h1230 + 16'(k), ok);
    pulse_done();
    repeat (2) @(negedge clk);
    check("R2 first fetch at base", first_rd, 32'h180);
    check("R5 reads for two descriptors", rd_cnt, 8);
    check("R5 last fetch of second descriptor", last_rd, 32'h18E);
    check("R5 data first buffer", {mem[8'h20], mem[8'h21]}, 32'h1230_1231);
    check("R5 data second buffer", {mem[8'h30], mem[8'h31]}, 32'h1232_1233);
    read_reg(3'd2, st);
    check("R6 chained status", st, 32'h4);

    // R10 write-one-to-clear
    reg_write(3'd2, 32'h0);
    read_reg(3'd2, st);
    check("R10 zero write keeps interrupt", st, 32'h4);
    reg_write(3'd2, 32'h4);
    read_reg(3'd2, st);
    check("R10 one write clears interrupt", st, 32'h0);
    check("R10 irq low after clear", {31'h0, irq}, 0);

    // R9 stop in mid transfer
    reg_write(3'd0, 32'h0);
    put_desc(8'h80, 32'h40, 32'h8000_0010);
    reg_write(3'd4, 32'h100);
    reg_write(3'd0, 32'h9);
    word_in(16'h0001, ok);
    word_in(16'h0002, ok);
    reg_write(3'd0, 32'h0);
    read_reg(3'd2, st);
    check("R9 status after mid stop", st, 32'h0);
    word_in(16'h0003, ok);
    check("R9 word refused after stop", {31'h0, ok}, 0);

    // R11 bus master disabled
    bm_en = 1'b0;
    req_cnt = 0;
    reg_write(3'd0, 32'h9);
    cnt = 0;
    for (int k = 0; k < 3; k++) begin word_in(16'h7700, ok); if (ok) cnt++; end
    pulse_done();
    repeat (2) @(negedge clk);
    read_reg(3'd2, st);
    check("R11 status without bus master", st, 32'h5);
    check("R11 words taken", cnt, 3);
    check("R11 no memory request", req_cnt, 0);
    reg_write(3'd0, 32'h0);
    read_reg(3'd2, st);
    check("R9 stop after device end", st, 32'h4);
    bm_en = 1'b1;
    reg_write(3'd2, 32'h4);

    // R12 zero count field means 65536 bytes
    put_desc(8'h80, 32'h0, 32'h8000_0000);
    reg_write(3'd4, 32'h100);
    reg_write(3'd0, 32'h1);
    @(negedge clk); dev_tx_ready = 1'b1;
    cnt = 0; guard = 0;
    while (cnt < 32768 && guard < 40000) begin
      @(negedge clk); #1;
      if (dev_tx_valid) cnt++;
      guard++;
    end
    @(negedge clk); dev_tx_ready = 1'b0;
    read_reg(3'd2, st);
    check("R12 active after 32768 words", st, 32'h1);
    dev_done = 1'b1;
    @(negedge clk); dev_done = 1'b0;
    repeat (2) @(negedge clk);
    check("R12 word count", cnt, 32768);
    read_reg(3'd2, st);
    check("R12 exact status", st, 32'h4);

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule